// File: doc/BRIEF.md
# Two-Line Instruction Prefetch Queue

This unit sits between an instruction memory port and the first decode stage. It holds two line buffers of sixteen bytes each and keeps them filled from memory without waiting for decode. At every cycle the decode front end sees a three-byte window. The window starts at the current fetch address and may run from one buffer into the other. The front end answers with the number of bytes it has used, from zero to three. When the read position leaves a buffer, that buffer is freed and refilled with the next sequential line.

A redirect input gives a new byte address. It discards both buffers and restarts fetching at the aligned line that holds the new address, with the read position at that address's offset within the line. The memory side takes one line request at a time through a valid/ready handshake, and it returns the data later with a valid strobe. If a response is still in flight when a redirect arrives, that response is marked stale and thrown away when it returns. Out of reset the unit starts fetching at the `RESET_ADDR` parameter.

Top module: `prefetch_queue`

## Requirements
- R1: While in reset and in the first cycle after reset, `win_avail` is 0. The first line requested is the aligned line holding `RESET_ADDR`.
- R2: `mem_req_addr` has its low four bits at zero. At most one request is outstanding, so `mem_req_valid` stays low from acceptance until the response strobe. Requests after a restart go to consecutive lines in ascending order.
- R3: `win_data[7:0]` holds the byte at `win_addr`, and bits [15:8] and [23:16] hold the next two addresses. `win_avail` counts the present bytes from byte 0 up to the first missing byte, at most 3. Window bytes at or beyond `win_avail` read as zero.
- R4: A window that starts at line offset 14 or 15 takes its later bytes from the other buffer. Those bytes count as present only once that buffer holds the next line.
- R5: Without a redirect, `win_addr` advances by `consume` on each edge, and a consume of 0 leaves it unchanged. `consume` never exceeds `win_avail`.
- R6: When the read position crosses into the other buffer, the buffer it left is freed. A request for the line after the one now being read is issued without any consume from decode.
- R7: With no consumption, the unit fills both buffers, which takes two requests. It then issues no further request.
- R8: In the cycle after a redirect, `win_avail` is 0 and `win_addr` equals the redirect address. A consume presented together with the redirect is ignored.
- R9: A response outstanding at a redirect is never written into a buffer. No new request is issued until that response has returned.
- R10: A request that is not accepted keeps `mem_req_valid` high and `mem_req_addr` unchanged on the next cycle, unless a redirect is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_valid | input | 1 | Flush and restart at `redirect_addr` |
| redirect_addr | input | ADDR_W | New fetch byte address |
| consume | input | 2 | Bytes taken from the window this cycle (0 to 3) |
| win_data | output | 24 | Window bytes, lowest address in bits [7:0] |
| win_avail | output | 2 | Number of present leading window bytes |
| win_addr | output | ADDR_W | Byte address of window byte 0 |
| mem_req_valid | output | 1 | Line request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Aligned line address requested |
| mem_rsp_valid | input | 1 | Line data returned for the outstanding request |
| mem_rsp_data | input | 128 | Line data, byte 0 in bits [7:0] |

## Verification
The checker assumes three things about the inputs. Decode never consumes more bytes than `win_avail` shows, except in a redirect cycle. The memory returns exactly one response per accepted request and none while nothing is outstanding. Line data arrives in request order. The bench meets the first assumption by reading `win_avail` before it chooses each consume value. Its memory model holds a single request in flight and answers it after a programmable latency. Stall patterns on `mem_req_ready` and a long latency let redirects land while a request waits for acceptance and while a response is still due.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  // Ping-pong organisation: exactly two line buffers.
  localparam int unsigned PFQ_NUM_BUF = 2;

  // Bookkeeping for the single outstanding line request.
  typedef struct packed {
    logic busy;    // a request is accepted and its response is due
    logic slot;    // buffer the response is destined for
    logic stale;   // a redirect happened since issue: drop the data
  } pfq_pend_t;
endpackage

// File: rtl/pfq_buffers.sv
module pfq_buffers #(
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned LINE_W = LINE_BYTES * 8,
  localparam int unsigned NBUF = pfq_pkg::PFQ_NUM_BUF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush_i,
  input  logic                   drain_en_i,
  input  logic                   drain_sel_i,
  input  logic                   fill_en_i,
  input  logic                   fill_sel_i,
  input  logic [LINE_W-1:0]      fill_data_i,
  output logic [NBUF-1:0]        full_o,
  output logic [NBUF*LINE_W-1:0] store_o
);

  logic [NBUF-1:0] full_q;
  logic [NBUF-1:0] full_d;

  // Occupancy next state: flush wins, else drain and fill touch
  // different slots by construction of the fetch order.
  always_comb begin
    full_d = full_q;
    if (flush_i) begin
      full_d = '0;
    end else begin
      if (drain_en_i) full_d[drain_sel_i] = 1'b0;
      if (fill_en_i)  full_d[fill_sel_i]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= full_d;
  end

  // Line storage: no reset, written only under its clock enable.
  for (genvar g = 0; g < NBUF; g++) begin : g_line
    logic              wr_en;
    logic [LINE_W-1:0] line_q;

    assign wr_en = fill_en_i && (fill_sel_i == g[0]);

    always_ff @(posedge clk) begin
      if (wr_en) line_q <= fill_data_i;
    end

    assign store_o[g*LINE_W +: LINE_W] = line_q;
  end

  assign full_o = full_q;

endmodule

// File: rtl/pfq_window.sv
module pfq_window #(
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned WIN_BYTES  = 3,
  localparam int unsigned OFS_W  = $clog2(LINE_BYTES),
  localparam int unsigned PTR_W  = OFS_W + 1,
  localparam int unsigned LINE_W = LINE_BYTES * 8,
  localparam int unsigned NBUF   = pfq_pkg::PFQ_NUM_BUF,
  localparam int unsigned CNT_W  = $clog2(WIN_BYTES + 1)
) (
  input  logic [PTR_W-1:0]       rd_ptr_i,
  input  logic [NBUF-1:0]        full_i,
  input  logic [NBUF*LINE_W-1:0] store_i,
  output logic [WIN_BYTES*8-1:0] win_data_o,
  output logic [CNT_W-1:0]       win_avail_o
);

  logic [WIN_BYTES-1:0] byte_ok;
  logic [7:0]           byte_val [WIN_BYTES];

  // One selector per window byte; the pointer wraps over both buffers.
  for (genvar i = 0; i < WIN_BYTES; i++) begin : g_byte
    logic [PTR_W-1:0] idx;
    assign idx         = rd_ptr_i + PTR_W'(i);
    assign byte_ok[i]  = full_i[idx[OFS_W]];
    assign byte_val[i] = store_i[int'(idx) * 8 +: 8];
  end

  // Leading-present count; bytes past the first hole are masked.
  always_comb begin
    logic run;
    run         = 1'b1;
    win_avail_o = '0;
    win_data_o  = '0;
    for (int i = 0; i < WIN_BYTES; i++) begin
      run = run & byte_ok[i];
      if (run) begin
        win_avail_o           = win_avail_o + CNT_W'(1);
        win_data_o[i*8 +: 8]  = byte_val[i];
      end
    end
  end

endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl #(
  parameter int unsigned LADDR_W    = 28,
  parameter logic [LADDR_W-1:0] RESET_LINE = '0,
  localparam int unsigned NBUF = pfq_pkg::PFQ_NUM_BUF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               redirect_i,
  input  logic [LADDR_W-1:0] redirect_line_i,
  input  logic [NBUF-1:0]    full_i,
  input  logic               cur_sel_i,
  input  logic               req_ready_i,
  input  logic               rsp_valid_i,
  output logic               req_valid_o,
  output logic [LADDR_W-1:0] req_line_o,
  output logic               fill_en_o,
  output logic               fill_sel_o
);
  import pfq_pkg::*;

  logic [LADDR_W-1:0] next_line_q, next_line_d;
  pfq_pend_t          pend_q, pend_d;
  logic               target;
  logic               need;
  logic               accept;
  logic               rsp_take;

  // Current buffer first when it is empty (only after a flush),
  // otherwise the one following it.
  assign target = full_i[cur_sel_i] ? ~cur_sel_i : cur_sel_i;
  assign need   = ~&full_i;

  assign req_valid_o = need && !pend_q.busy && !redirect_i;
  assign req_line_o  = next_line_q;
  assign accept      = req_valid_o && req_ready_i;
  assign rsp_take    = rsp_valid_i && pend_q.busy;

  assign fill_en_o  = rsp_take && !pend_q.stale && !redirect_i;
  assign fill_sel_o = pend_q.slot;

  always_comb begin
    next_line_d = next_line_q;
    pend_d      = pend_q;
    if (redirect_i) begin
      next_line_d = redirect_line_i;
    end else if (accept) begin
      next_line_d = next_line_q + LADDR_W'(1);
    end

    if (accept) begin
      pend_d.busy  = 1'b1;
      pend_d.slot  = target;
      pend_d.stale = 1'b0;
    end else if (rsp_take) begin
      pend_d.busy  = 1'b0;
      pend_d.stale = 1'b0;
    end else if (redirect_i && pend_q.busy) begin
      pend_d.stale = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_line_q <= RESET_LINE;
      pend_q      <= '0;
    end else begin
      next_line_q <= next_line_d;
      pend_q      <= pend_d;
    end
  end

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned WIN_BYTES  = 3,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int unsigned OFS_W   = $clog2(LINE_BYTES),
  localparam int unsigned PTR_W   = OFS_W + 1,
  localparam int unsigned LADDR_W = ADDR_W - OFS_W,
  localparam int unsigned LINE_W  = LINE_BYTES * 8,
  localparam int unsigned CNT_W   = $clog2(WIN_BYTES + 1),
  localparam int unsigned NBUF    = pfq_pkg::PFQ_NUM_BUF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   redirect_valid,
  input  logic [ADDR_W-1:0]      redirect_addr,
  input  logic [CNT_W-1:0]       consume,
  output logic [WIN_BYTES*8-1:0] win_data,
  output logic [CNT_W-1:0]       win_avail,
  output logic [ADDR_W-1:0]      win_addr,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [ADDR_W-1:0]      mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [LINE_W-1:0]      mem_rsp_data
);

  localparam logic [LADDR_W-1:0] RESET_LINE = RESET_ADDR[ADDR_W-1:OFS_W];
  localparam logic [PTR_W-1:0]   RESET_PTR  = {1'b0, RESET_ADDR[OFS_W-1:0]};

  logic [PTR_W-1:0]       rd_ptr_q, rd_ptr_d;
  logic [LADDR_W-1:0]     cur_line_q, cur_line_d;
  logic                   crossed;
  logic [NBUF-1:0]        full;
  logic [NBUF*LINE_W-1:0] store;
  logic                   fill_en;
  logic                   fill_sel;
  logic [LADDR_W-1:0]     req_line;

  // Read position: redirect restarts in slot 0, otherwise advance.
  always_comb begin
    rd_ptr_d   = rd_ptr_q;
    cur_line_d = cur_line_q;
    crossed    = 1'b0;
    if (redirect_valid) begin
      rd_ptr_d   = {1'b0, redirect_addr[OFS_W-1:0]};
      cur_line_d = redirect_addr[ADDR_W-1:OFS_W];
    end else begin
      rd_ptr_d = rd_ptr_q + PTR_W'(consume);
      crossed  = rd_ptr_d[OFS_W] != rd_ptr_q[OFS_W];
      if (crossed) cur_line_d = cur_line_q + LADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q   <= RESET_PTR;
      cur_line_q <= RESET_LINE;
    end else begin
      rd_ptr_q   <= rd_ptr_d;
      cur_line_q <= cur_line_d;
    end
  end

  pfq_buffers #(
    .LINE_BYTES (LINE_BYTES)
  ) u_bufs (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (redirect_valid),
    .drain_en_i  (crossed),
    .drain_sel_i (rd_ptr_q[OFS_W]),
    .fill_en_i   (fill_en),
    .fill_sel_i  (fill_sel),
    .fill_data_i (mem_rsp_data),
    .full_o      (full),
    .store_o     (store)
  );

  pfq_window #(
    .LINE_BYTES (LINE_BYTES),
    .WIN_BYTES  (WIN_BYTES)
  ) u_win (
    .rd_ptr_i    (rd_ptr_q),
    .full_i      (full),
    .store_i     (store),
    .win_data_o  (win_data),
    .win_avail_o (win_avail)
  );

  pfq_fetch_ctl #(
    .LADDR_W    (LADDR_W),
    .RESET_LINE (RESET_LINE)
  ) u_fetch (
    .clk             (clk),
    .rst_n           (rst_n),
    .redirect_i      (redirect_valid),
    .redirect_line_i (redirect_addr[ADDR_W-1:OFS_W]),
    .full_i          (full),
    .cur_sel_i       (rd_ptr_q[OFS_W]),
    .req_ready_i     (mem_req_ready),
    .rsp_valid_i     (mem_rsp_valid),
    .req_valid_o     (mem_req_valid),
    .req_line_o      (req_line),
    .fill_en_o       (fill_en),
    .fill_sel_o      (fill_sel)
  );

  assign win_addr     = {cur_line_q, rd_ptr_q[OFS_W-1:0]};
  assign mem_req_addr = {req_line, {OFS_W{1'b0}}};

endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redirect_valid,
  input logic [ADDR_W-1:0] redirect_addr,
  input logic [CNT_W-1:0]  consume,
  input logic [CNT_W-1:0]  win_avail,
  input logic [ADDR_W-1:0] win_addr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);

  // Independent count of requests in flight, seen from the ports.
  logic [1:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= '0;
    end else begin
      case ({mem_req_valid && mem_req_ready, mem_rsp_valid})
        2'b10:   inflight <= inflight + 2'd1;
        2'b01:   inflight <= inflight - 2'd1;
        default: inflight <= inflight;
      endcase
    end
  end

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> inflight == 2'd0); // R2

  AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> inflight != 2'd0); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (redirect_valid || (mem_req_valid && $stable(mem_req_addr)))); // R10

  AST_CONSUME_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_valid |-> consume <= win_avail); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_valid |=> win_addr == $past(win_addr) + ADDR_W'($past(consume))); // R5

  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (win_avail == '0) && (win_addr == $past(redirect_addr))); // R8

endmodule

bind prefetch_queue prefetch_queue_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .redirect_valid (redirect_valid),
  .redirect_addr  (redirect_addr),
  .consume        (consume),
  .win_avail      (win_avail),
  .win_addr       (win_addr),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_rsp_valid  (mem_rsp_valid)
);

// File: tb/prefetch_queue_test.sv
module prefetch_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          redirect_valid;
  logic [AW-1:0] redirect_addr;
  logic [1:0]    consume;
  logic [23:0]   win_data;
  logic [1:0]    win_avail;
  logic [AW-1:0] win_addr;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [127:0]  mem_rsp_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_queue uut (
    .clk (clk), .rst_n (rst_n),
    .redirect_valid (redirect_valid), .redirect_addr (redirect_addr),
    .consume (consume), .win_data (win_data), .win_avail (win_avail),
    .win_addr (win_addr), .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready), .mem_req_addr (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data)
  );

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [127:0] line_data(input logic [AW-5:0] ln);
    logic [127:0] d;
    for (int b = 0; b < 16; b++) d[b*8 +: 8] = mbyte({ln, 4'b0} + AW'(b));
    return d;
  endfunction

  task automatic check(input string req, input logic ok, input longint got, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Scoreboard: expected line requests in issue order.
  logic [AW-5:0] exp_q [$];
  task automatic expect_line(input logic [AW-5:0] ln);
    exp_q.push_back(ln);
  endtask

  // Memory model and request monitor.
  logic [AW-5:0] mm_line;
  int            mm_cnt  = 0;
  bit            mm_busy = 0;
  int            lat     = 2;
  bit            stall_en = 0;
  int            ncyc    = 0;
  int            n_acc   = 0;
  bit            prev_wait = 0;
  logic [AW-1:0] prev_addr;

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      ncyc++;
      mem_rsp_valid = 1'b0;
      if (mm_busy) begin
        if (mm_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = line_data(mm_line);
          mm_busy       = 0;
        end else begin
          mm_cnt--;
        end
      end
      mem_req_ready = !(stall_en && (ncyc % 3) != 0);
      #1;
      if (rst_n) begin
        if (prev_wait && !redirect_valid)
          check("R10 held request", mem_req_valid && mem_req_addr == prev_addr,
                {mem_req_valid, mem_req_addr}, {1'b1, prev_addr});
        prev_wait = mem_req_valid && !mem_req_ready;
        prev_addr = mem_req_addr;
        if (mem_req_valid && mem_req_ready) begin
          if (exp_q.size() == 0) begin
            check("R2 unexpected request", 1'b0, mem_req_addr, 0);
          end else begin
            logic [AW-5:0] e;
            e = exp_q.pop_front();
            check("R2 request address", mem_req_addr == {e, 4'b0}, mem_req_addr, {e, 4'b0});
          end
          mm_busy = 1;
          mm_line = mem_req_addr[AW-1:4];
          mm_cnt  = lat;
          n_acc++;
        end
      end
    end
  end

  task automatic cyc(input logic [1:0] c);
    @(posedge clk); #1;
    consume        = c;
    redirect_valid = 1'b0;
  endtask

  task automatic redir(input logic [AW-1:0] a, input logic [1:0] c);
    @(posedge clk); #1;
    redirect_valid = 1'b1;
    redirect_addr  = a;
    consume        = c;
  endtask

  task automatic check_window(input string req, input logic [AW-1:0] a);
    for (int i = 0; i < 3; i++) begin
      logic [7:0] e;
      e = (i < int'(win_avail)) ? mbyte(a + AW'(i)) : 8'h00;
      check(req, win_data[i*8 +: 8] == e, win_data[i*8 +: 8], e);
    end
  endtask

  // Watchdog.
  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] model;
    int            k;
    int            acc0;
    rst_n          = 1'b0;
    redirect_valid = 1'b0;
    redirect_addr  = '0;
    consume        = '0;
    expect_line(0);       // R1: reset line first
    expect_line(1);       // R6: then the following line
    repeat (3) @(posedge clk);
    #1;
    check("R1 avail in reset", win_avail == 0, win_avail, 0);
    rst_n = 1'b1;
    check("R1 avail after reset", win_avail == 0, win_avail, 0);

    // R7: fill without consuming, then stop.
    repeat (15) cyc(0);
    check("R5 idle address", win_addr == 0, win_addr, 0);
    check("R7 window full", win_avail == 3, win_avail, 3);
    check_window("R3 window bytes", 0);
    check("R7 two requests only", n_acc == 2, n_acc, 2);

    // Streaming with stalls; R4 crossings and R6 refills.
    stall_en = 1;
    for (int l = 2; l <= 7; l++) expect_line(l[AW-5:0]);
    model = 0;
    k     = 0;
    while (model < 100) begin
      logic [1:0] n;
      @(posedge clk); #1;
      redirect_valid = 1'b0;
      check("R5 address step", win_addr == model, win_addr, model);
      if (model[3:0] >= 4'd14) check_window("R4 spanning window", model);
      else                     check_window("R3 window bytes", model);
      n = 2'((k % 3) + 1);
      if (n > win_avail) n = win_avail;
      consume = n;
      model   = model + AW'(n);
      k++;
    end
    cyc(0);
    repeat (20) cyc(0);
    check("R6 refill count", n_acc == 8, n_acc, 8);
    check("R6 queue drained", exp_q.size() == 0, exp_q.size(), 0);
    check("R5 final address", win_addr == model, win_addr, model);
    check("R7 window refilled", win_avail == 3, win_avail, 3);
    stall_en = 0;

    // R8: redirect into offset 14, consume ignored.
    acc0 = n_acc;
    expect_line(28'h105);
    expect_line(28'h106);
    redir(32'h105E, 2'd3);
    cyc(0);
    check("R8 address after redirect", win_addr == 32'h105E, win_addr, 32'h105E);
    check("R8 flushed window", win_avail == 0, win_avail, 0);
    repeat (14) cyc(0);
    check("R4 window across lines", win_avail == 3, win_avail, 3);
    check_window("R4 spanning bytes", 32'h105E);
    check("R7 restart requests", n_acc == acc0 + 2, n_acc, acc0 + 2);

    // R9: redirect while a response is still due.
    lat = 8;
    expect_line(28'h200);
    redir(32'h2008, 2'd0);
    cyc(0);
    while (!mm_busy) cyc(0);
    expect_line(28'h300);
    expect_line(28'h301);
    redir(32'h3008, 2'd0);
    cyc(0);
    for (int t = 0; t < 45; t++) begin
      check("R9 address held", win_addr == 32'h3008, win_addr, 32'h3008);
      if (win_avail != 0) check_window("R9 no stale bytes", 32'h3008);
      cyc(0);
    end
    check("R9 window after restart", win_avail == 3, win_avail, 3);
    check_window("R9 fresh bytes", 32'h3008);
    check("R9 scoreboard empty", exp_q.size() == 0, exp_q.size(), 0);
    lat = 2;

    repeat (3) cyc(0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule